// File: doc/BRIEF.md
# Register-Window Stream Write Bridge

This block converts processor writes to a two-word register window into beats on a streaming master port that uses AXI4-Stream valid/ready signalling. Each word in the window is write-only and one stream word wide. A write to word 0 sends the written value as a beat with the last-beat flag low. A write to word 1 sends it with the flag high, so software can mark where a packet ends by choosing the address.

The bridge blocks. It holds back the write acknowledge strobe until the stream sink has taken the beat, so the requesting bus master stays stalled for as long as the sink applies back-pressure. Reads of the window are answered in the same cycle with all-zero data. A read therefore cannot wait for an acknowledge that never comes, and it does not disturb a beat in flight. Byte strobes on writes are ignored, and the whole word is always sent.

Top module: `regwin_stream_bridge`

## Requirements
- R1: After synchronous active-high reset, `m_tvalid_o`, `wr_ack_o` and `rd_ack_o` are low, and no beat is pending.
- R2: A write request (`req_i`=1, `req_is_wr_i`=1) when no beat is pending makes `m_tvalid_o` high in the next cycle, with `m_tdata_o` equal to the write data.
- R3: The last-beat flag of the beat equals the address bit: `addr_i`=0 gives `m_tlast_o`=0, and `addr_i`=1 gives `m_tlast_o`=1.
- R4: While `m_tvalid_o` is high and `m_tready_i` is low, `m_tvalid_o`, `m_tdata_o` and `m_tlast_o` keep their values into the next cycle.
- R5: `wr_ack_o` is high only in a cycle where `m_tvalid_o` and `m_tready_i` are both high, and it is high for exactly one cycle per beat.
- R6: In the cycle after the handshake, `m_tvalid_o` is low.
- R7: `wr_strb_i` has no effect: the full write word appears on `m_tdata_o` whatever the strobe pattern.
- R8: A read request (`req_i`=1, `req_is_wr_i`=0) raises `rd_ack_o` in the same cycle, with `rd_data_o` all zero.
- R9: A read request leaves `m_tvalid_o`, `m_tdata_o` and `m_tlast_o` unchanged, including while a beat is waiting.
- R10: `rd_ack_o` is high only together with a read request and never with a write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe from the register window |
| req_is_wr_i | input | 1 | 1 = write request, 0 = read request |
| addr_i | input | 1 | Word select: 0 = beat not last, 1 = last beat |
| wr_data_i | input | DATA_W | Write data |
| wr_strb_i | input | DATA_W/8 | Byte strobes (ignored) |
| rd_ack_o | output | 1 | Read acknowledge strobe |
| rd_data_o | output | DATA_W | Read data (always zero) |
| wr_ack_o | output | 1 | Write acknowledge strobe |
| m_tvalid_o | output | 1 | Stream valid |
| m_tdata_o | output | DATA_W | Stream data |
| m_tlast_o | output | 1 | Stream last-beat flag |
| m_tready_i | input | 1 | Stream ready from the sink |

## Verification
Two events can land in the same cycle: the write acknowledge for a finishing stream handshake, and the same-cycle acknowledge of a read request. The bench creates this overlap by raising a read request in the very cycle it raises `m_tready_i` for a held beat. In that cycle it expects both strobes high and zero read data. In the next cycle it expects `m_tvalid_o` low, with the read having caused no extra beat. The bench also sends reads during stall cycles and checks that the held beat does not move.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  // Last-beat flag chosen by the window word address.
  function automatic logic beat_last(input logic word_sel);
    return word_sel;
  endfunction

  // Handshake completes when valid and ready meet.
  function automatic logic fire(input logic valid, input logic ready);
    return valid & ready;
  endfunction
endpackage

// File: rtl/rsb_beat_reg.sv
module rsb_beat_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              fire,
  input  logic              word_sel,
  input  logic [DATA_W-1:0] data_in,
  output logic              valid,
  output logic [DATA_W-1:0] data_out,
  output logic              last_out
);
  import rsb_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (accept) begin
      valid <= 1'b1;
    end else if (fire) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      data_out <= data_in;
      last_out <= beat_last(word_sel);
    end
  end

  a_r4_hold_beat: assert property (@(posedge clk) disable iff (rst)
    (valid && !fire) |=> (valid && $stable(data_out) && $stable(last_out)));
  a_r6_drop_after_fire: assert property (@(posedge clk) disable iff (rst)
    (fire && !accept) |=> !valid);
  a_r2_rise_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> (valid && data_out == $past(data_in)));
endmodule

// File: rtl/rsb_ack_unit.sv
module rsb_ack_unit (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic req_is_wr,
  input  logic fire,
  output logic rd_ack,
  output logic wr_ack
);
  assign rd_ack = req & ~req_is_wr;
  assign wr_ack = fire;

  a_r10_rd_only_on_read: assert property (@(posedge clk) disable iff (rst)
    rd_ack |-> (req && !req_is_wr));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_ack |=> !wr_ack);
endmodule

// File: rtl/regwin_stream_bridge.sv
module regwin_stream_bridge #(
  parameter int DATA_W = 32,
  parameter int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              req_is_wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [STRB_W-1:0] wr_strb_i,
  output logic              rd_ack_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              wr_ack_o,
  output logic              m_tvalid_o,
  output logic [DATA_W-1:0] m_tdata_o,
  output logic              m_tlast_o,
  input  logic              m_tready_i
);
  import rsb_pkg::*;

  logic accept_w;
  logic fire_w;

  assign accept_w  = req_i & req_is_wr_i & ~m_tvalid_o;
  assign fire_w    = fire(m_tvalid_o, m_tready_i);
  assign rd_data_o = '0;

  rsb_beat_reg #(.DATA_W(DATA_W)) u_beat (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept_w),
    .fire     (fire_w),
    .word_sel (addr_i),
    .data_in  (wr_data_i),
    .valid    (m_tvalid_o),
    .data_out (m_tdata_o),
    .last_out (m_tlast_o)
  );

  rsb_ack_unit u_ack (
    .clk       (clk),
    .rst       (rst),
    .req       (req_i),
    .req_is_wr (req_is_wr_i),
    .fire      (fire_w),
    .rd_ack    (rd_ack_o),
    .wr_ack    (wr_ack_o)
  );

  a_r5_ack_in_handshake: assert property (@(posedge clk) disable iff (rst)
    wr_ack_o |-> (m_tvalid_o && m_tready_i));
  a_r8_read_zero: assert property (@(posedge clk) disable iff (rst)
    rd_ack_o |-> (rd_data_o == '0));
  a_r3_last_from_addr: assert property (@(posedge clk) disable iff (rst)
    accept_w |=> (m_tlast_o == $past(addr_i)));
  a_r7_full_word: assert property (@(posedge clk) disable iff (rst)
    (accept_w && wr_strb_i != '1) |=> (m_tdata_o == $past(wr_data_i)));
  a_r9_read_keeps_beat: assert property (@(posedge clk) disable iff (rst)
    (req_i && !req_is_wr_i && m_tvalid_o && !m_tready_i) |=>
      (m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o)));
endmodule

// File: tb/tb_regwin_stream_bridge.sv
module tb_regwin_stream_bridge;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, is_wr = 1'b0, addr = 1'b0, tready = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [STRB_W-1:0] strb = '0;
  logic rd_ack, wr_ack, tvalid, tlast;
  logic [DATA_W-1:0] rdata, tdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  regwin_stream_bridge #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .req_i(req), .req_is_wr_i(is_wr), .addr_i(addr),
    .wr_data_i(wdata), .wr_strb_i(strb), .rd_ack_o(rd_ack), .rd_data_o(rdata),
    .wr_ack_o(wr_ack), .m_tvalid_o(tvalid), .m_tdata_o(tdata),
    .m_tlast_o(tlast), .m_tready_i(tready)
  );

  task automatic chk(input string req_id, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_id, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pattern(input int i, input int a);
    return (32'h9E37_79B9 * (i + 1)) ^ (a << 31) ^ i;
  endfunction

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 tvalid", tvalid, 0);
    chk("R1 wr_ack", wr_ack, 0);
    chk("R1 rd_ack", rd_ack, 0);

    for (int a = 0; a < 2; a++) begin
      for (int i = 0; i < 8; i++) begin
        for (int stall = 0; stall < 4; stall++) begin
          logic [DATA_W-1:0] d;
          d = pattern(i * 4 + stall, a);
          @(negedge clk);
          req = 1; is_wr = 1; addr = a[0]; wdata = d; strb = STRB_W'(i * 3 + stall);
          #1;
          chk("R10 no rd_ack on write", rd_ack, 0);
          @(negedge clk);
          req = 0; is_wr = 0; wdata = ~d; strb = '1;
          #1;
          chk("R2 tvalid", tvalid, 1);
          chk("R2 R7 tdata", tdata, d);
          chk("R3 tlast", tlast, a[0]);
          chk("R5 no early ack", wr_ack, 0);
          for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            if (k == 0) begin req = 1; is_wr = 0; end
            #1;
            if (k == 0) begin
              chk("R8 rd_ack", rd_ack, 1);
              chk("R8 rd_data", rdata, 0);
            end
            chk("R4 R9 hold valid", tvalid, 1);
            chk("R4 R9 hold data", tdata, d);
            chk("R4 R9 hold last", tlast, a[0]);
            chk("R5 no ack in stall", wr_ack, 0);
            req = 0;
          end
          @(negedge clk);
          tready = 1;
          if (stall[0]) begin req = 1; is_wr = 0; end
          #1;
          chk("R5 ack at handshake", wr_ack, 1);
          chk("R8 rd_ack overlap", rd_ack, stall[0]);
          if (stall[0]) chk("R8 rd_data overlap", rdata, 0);
          @(negedge clk);
          tready = 0; req = 0;
          #1;
          chk("R6 tvalid dropped", tvalid, 0);
          chk("R5 single pulse", wr_ack, 0);
        end
      end
    end

    // Read while idle creates no beat.
    @(negedge clk); req = 1; is_wr = 0; tready = 1;
    #1; chk("R8 idle rd_ack", rd_ack, 1);
    @(negedge clk); req = 0;
    #1; chk("R9 idle read no beat", tvalid, 0);
    chk("R5 idle no ack", wr_ack, 0);
    tready = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule